// File: doc/BRIEF.md
# Zero-turnaround pipelined SRAM core

This block is a synchronous single-port memory. It takes any mix of reads and writes back to back, with no idle cycle when the bus changes direction. Address, command and select are registered at the rising edge that loads an operation. The data for a write arrives two enabled edges later, which is the same point in the pipeline where a read's data leaves. Reads and writes therefore use the data buses in the same slot, and no turnaround cycle is needed. A single active-low clock enable stalls the whole pipeline. The array is written a byte at a time.

After an operation has been loaded, raising the advance strobe keeps the same operation type running at the next burst address. The burst address comes from a 2-bit counter that wraps, in linear or interleaved order. The output enable is asynchronous. It gates the read bus and a valid flag that replaces a tri-state driver.

Top module: `zt_sram`

## Requirements
- R1: At an enabled edge (`cken_n`=0) with `burst_adv`=0 and `sel`=1, a new operation is loaded from `addr`. With `we_n`=1 it is a read, and with `we_n`=0 it is a write.
- R2: A read loaded at enabled edge N presents the word at its address on `rdata`, with `rvalid`=1, after enabled edge N+2, provided `oe_n` is low.
- R3: A write loaded at enabled edge N takes `wdata` and `be_n` at enabled edge N+2. Each bit `be_n[b]`=0 writes byte b, which is `wdata[8b+7:8b]`, and leaves the other bytes unchanged.
- R4: A write whose `be_n` is all ones at its data edge leaves the memory unchanged.
- R5: At an edge with `cken_n`=1, every input is ignored. No operation is loaded, no memory byte changes, and the output holds its previous value.
- R6: A load with `sel`=0 is a deselect. `burst_adv`=1 after a deselect, and after reset, stays deselected. A deselect slot gives `rvalid`=0 and `rdata`=0 two enabled edges later.
- R7: `burst_adv`=1 after a read or write continues that type at the next burst address, with the counter k stepping 1,2,3,0,... The upper address bits are kept. The low two bits are (start+k) mod 4 when `burst_lin`=1, and start XOR k when `burst_lin`=0.
- R8: While `oe_n`=1, `rvalid`=0 and `rdata`=0 within the same cycle, without waiting for a clock edge.
- R9: A read loaded one edge after a write to the same address returns that write's data, merged byte by byte over the old word.
- R10: `rvalid` is 0 in output slots that belong to write operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline registers |
| cken_n | input | 1 | Active-low clock enable; high freezes the block |
| sel | input | 1 | Chip select sampled at a load |
| burst_adv | input | 1 | 0 loads a new operation, 1 advances the burst |
| we_n | input | 1 | Active-low write command sampled at a load |
| be_n | input | 4 | Active-low byte enables for the write data slot |
| addr | input | 8 | Word address sampled at a load |
| wdata | input | 32 | Write data for the write data slot |
| burst_lin | input | 1 | 1 selects linear, 0 interleaved burst order |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid, stands in for bus drive |

## Verification
A write can commit its data at the same edge that a read to the same address samples the array. The bench provokes this by loading a read directly behind a write to one address and sweeping all sixteen byte-enable patterns. A random mix over four addresses repeats the case many times. Clock-enable stalls are placed at random and can fall exactly on a commit edge, so a stalled edge must not write anything. Every output slot is compared with a reference memory that the bench updates, at each enabled edge, from the commands and data slots it drove.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

endpackage

// File: rtl/zt_sram_issue.sv
module zt_sram_issue
    import zt_sram_pkg::*;
#(
    parameter int AW        = 8,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          sel,
    input  logic          burst_adv,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          burst_lin,
    output op_e           op1,
    output logic [AW-1:0] addr1
);

    localparam int BW = $clog2(BURST_LEN);

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] base;
        logic [BW-1:0] cnt;
    } issue_t;

    issue_t d, q;
    logic [BW-1:0] offset;

    always_comb begin
        d = q;
        if (!hold) begin
            if (!burst_adv) begin
                d.base = addr;
                d.cnt  = '0;
                if (sel) begin
                    d.op = we_n ? OP_RD : OP_WR;
                end else begin
                    d.op = OP_IDLE;
                end
            end else if (q.op != OP_IDLE) begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (burst_lin) begin
            offset = q.base[BW-1:0] + q.cnt;
        end else begin
            offset = q.base[BW-1:0] ^ q.cnt;
        end
    end

    assign op1   = q.op;
    assign addr1 = {q.base[AW-1:BW], offset};

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !burst_adv && sel) |=> (addr1 == $past(addr)) && ((op1 == OP_RD) == $past(we_n))); // R1

    AST_DESEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && burst_adv && q.op == OP_IDLE) |=> (op1 == OP_IDLE)); // R6

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && burst_adv && q.op != OP_IDLE) |=> (q.op == $past(q.op)) && (q.cnt == $past(q.cnt) + 1'b1)); // R7

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
    parameter int AW = 8,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [NB*8-1:0] wr_data,
    input  logic [NB-1:0]   wr_be_n,
    input  logic [AW-1:0]   rd_addr,
    output logic [NB*8-1:0] rd_word
);

    localparam int DW    = NB * 8;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          hit;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (!wr_be_n[b]) begin
                    mem[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    assign hit = wr_en && (wr_addr == rd_addr);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign rd_word[b*8 +: 8] = (hit && !wr_be_n[b]) ? wr_data[b*8 +: 8]
                                                         : mem[rd_addr][b*8 +: 8];
    end

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe
    import zt_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  op_e           op1,
    input  logic [AW-1:0] addr1,
    input  logic [DW-1:0] rd_word,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          out_vld,
    output logic [DW-1:0] out_data
);

    typedef struct packed {
        op_e           op2;
        logic [AW-1:0] addr2;
        logic [DW-1:0] rdat2;
        logic          ovld;
        logic [DW-1:0] odat;
    } pipe_t;

    pipe_t d, q;

    always_comb begin
        d = q;
        if (!hold) begin
            d.op2   = op1;
            d.addr2 = addr1;
            d.rdat2 = rd_word;
            d.ovld  = (q.op2 == OP_RD);
            if (q.op2 == OP_RD) begin
                d.odat = q.rdat2;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en    = !hold && (q.op2 == OP_WR);
    assign wr_addr  = q.addr2;
    assign out_vld  = q.ovld;
    assign out_data = q.odat;

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q)); // R5

    AST_SLOT_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && q.op2 != OP_RD) |=> !out_vld); // R10

    AST_READ_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && q.op2 == OP_RD) |=> out_vld && (out_data == $past(q.rdat2))); // R2

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int AW        = 8,
    parameter int NB        = 4,
    parameter int BURST_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cken_n,
    input  logic            sel,
    input  logic            burst_adv,
    input  logic            we_n,
    input  logic [NB-1:0]   be_n,
    input  logic [AW-1:0]   addr,
    input  logic [NB*8-1:0] wdata,
    input  logic            burst_lin,
    input  logic            oe_n,
    output logic [NB*8-1:0] rdata,
    output logic            rvalid
);

    localparam int DW = NB * 8;

    op_e           op1;
    logic [AW-1:0] addr1;
    logic [DW-1:0] rd_word;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          out_vld;
    logic [DW-1:0] out_data;

    zt_sram_issue #(.AW(AW), .BURST_LEN(BURST_LEN)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (cken_n),
        .sel       (sel),
        .burst_adv (burst_adv),
        .we_n      (we_n),
        .addr      (addr),
        .burst_lin (burst_lin),
        .op1       (op1),
        .addr1     (addr1)
    );

    zt_sram_array #(.AW(AW), .NB(NB)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wdata),
        .wr_be_n (be_n),
        .rd_addr (addr1),
        .rd_word (rd_word)
    );

    zt_sram_pipe #(.AW(AW), .DW(DW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cken_n),
        .op1      (op1),
        .addr1    (addr1),
        .rd_word  (rd_word),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .out_vld  (out_vld),
        .out_data (out_data)
    );

    assign rvalid = out_vld && !oe_n;
    assign rdata  = rvalid ? out_data : '0;

endmodule

// File: tb/zt_sram_test.sv
module zt_sram_test;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int DW = NB * 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, cken_n, sel, burst_adv, we_n, burst_lin, oe_n;
    logic [NB-1:0] be_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rvalid;

    zt_sram #(.AW(AW), .NB(NB), .BURST_LEN(4)) uut (
        .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .sel(sel),
        .burst_adv(burst_adv), .we_n(we_n), .be_n(be_n), .addr(addr),
        .wdata(wdata), .burst_lin(burst_lin), .oe_n(oe_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] refm [1 << AW];
    int            m_op1 = 0;   // 0 idle, 1 read, 2 write
    int            m_op2 = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic [AW-1:0] m_addr2 = '0;
    bit            exp_v = 1'b0;
    logic [DW-1:0] exp_d = '0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] m_addr1();
        logic [1:0] off;
        off = burst_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        return {m_base[AW-1:2], off};
    endfunction

    task automatic model_edge();
        if (cken_n) return;
        if (m_op2 == 2) begin
            for (int b = 0; b < NB; b++)
                if (!be_n[b]) refm[m_addr2][b*8 +: 8] = wdata[b*8 +: 8];
        end
        exp_v = (m_op2 == 1);
        if (m_op2 == 1) exp_d = refm[m_addr2];
        m_op2   = m_op1;
        m_addr2 = m_addr1();
        if (!burst_adv) begin
            m_base = addr;
            m_cnt  = 2'd0;
            m_op1  = sel ? (we_n ? 1 : 2) : 0;
        end else if (m_op1 != 0) begin
            m_cnt = m_cnt + 2'd1;
        end
    endtask

    task automatic compare(input string req);
        bit v;
        v = exp_v && !oe_n;
        chk(rvalid == v, req, {31'd0, rvalid}, {31'd0, v});
        if (v) chk(rdata == exp_d, req, rdata, exp_d);
        else   chk(rdata == '0, req, rdata, '0);
    endtask

    task automatic cyc(input bit ce_n, input bit s, input bit adv, input bit wen,
                       input logic [AW-1:0] a, input logic [NB-1:0] ben,
                       input logic [DW-1:0] wd, input bit oen, input string req);
        @(negedge clk);
        cken_n = ce_n; sel = s; burst_adv = adv; we_n = wen;
        addr = a; be_n = ben; wdata = wd; oe_n = oen;
        @(posedge clk);
        model_edge();
        #2;
        compare(req);
    endtask

    task automatic idle(input string req);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, '0, '1, 32'hDEAD_BEEF, 1'b0, req);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return (32'h0101_0101 * i) ^ 32'hA55A_0000;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cken_n = 1'b0; sel = 1'b0; burst_adv = 1'b0; we_n = 1'b1;
        burst_lin = 1'b1; oe_n = 1'b0; be_n = '1; addr = '0; wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R6: reset state, nothing valid
        chk(rvalid == 1'b0, "R6", {31'd0, rvalid}, '0);
        chk(rdata == '0, "R6", rdata, '0);

        // R3: fill every word with full byte enables, data lags by two slots
        for (int i = 0; i < (1 << AW) + 2; i++) begin
            if (i < (1 << AW))
                cyc(1'b0, 1'b1, 1'b0, 1'b0, i[AW-1:0], (i >= 2) ? 4'h0 : 4'hF,
                    (i >= 2) ? pat(i - 2) : '0, 1'b0, "R3");
            else
                cyc(1'b0, 1'b0, 1'b0, 1'b1, '0, 4'h0, pat(i - 2), 1'b0, "R3");
        end

        // R1 and R2: read every word back to back
        for (int i = 0; i < (1 << AW); i++)
            cyc(1'b0, 1'b1, 1'b0, 1'b1, i[AW-1:0], '1, '0, 1'b0, "R2");
        idle("R2");
        idle("R1");

        // R9 with R3/R4: write then read the same word, all byte-enable patterns
        for (int p = 0; p < 16; p++) begin
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h40, '1, '0, 1'b0, "R3");
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h40, '1, '0, 1'b0, "R9");
            cyc(1'b0, 1'b0, 1'b0, 1'b1, '0, p[3:0], 32'h1122_3344 + p, 1'b0,
                (p == 15) ? "R4" : "R10");
            idle("R9");
            idle("R3");
        end

        // R7: write bursts then read bursts, every start, both orders, with wrap
        for (int lin = 0; lin < 2; lin++) begin
            burst_lin = lin[0];
            for (int st = 0; st < 4; st++) begin
                cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h90 + st[7:0], '1, '0, 1'b0, "R7");
                for (int k = 0; k < 5; k++)
                    cyc(1'b0, 1'b0, 1'b1, 1'b1, '0, (k >= 1) ? 4'h0 : 4'hF,
                        pat(100 + st * 8 + k + lin * 40), 1'b0, "R7");
                cyc(1'b0, 1'b0, 1'b0, 1'b1, '0, 4'h0, pat(200 + st), 1'b0, "R7");
                cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h90 + st[7:0], '1, '0, 1'b0, "R7");
                for (int k = 0; k < 5; k++)
                    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h33, 4'h0, 32'hBAD0_0000, 1'b0, "R7");
                idle("R7");
                idle("R7");
            end
        end
        burst_lin = 1'b1;

        // R6: deselect, then advance with write-looking garbage
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 4'h0, 32'hFFFF_FFFF, 1'b0, "R6");
        for (int k = 0; k < 4; k++)
            cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h10, 4'h0, 32'hFFFF_FFFF, 1'b0, "R6");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h10, '1, '0, 1'b0, "R1");
        idle("R6");
        idle("R6");

        // R5: stalls during a read and on a write commit edge
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h20, '1, '0, 1'b0, "R5");
        idle("R5");
        idle("R5");
        for (int k = 0; k < 3; k++)
            cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h21, 4'h0, 32'h5555_AAAA, 1'b0, "R5");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h20, '1, '0, 1'b0, "R5");
        idle("R5");
        cyc(1'b1, 1'b0, 1'b0, 1'b1, '0, 4'h0, 32'h0BAD_0BAD, 1'b0, "R5");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, '0, 4'h0, 32'h6666_7777, 1'b0, "R5");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h20, '1, '0, 1'b0, "R5");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h21, '1, '0, 1'b0, "R5");
        idle("R5");
        idle("R5");

        // R8: output enable acts inside a cycle
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h05, '1, '0, 1'b0, "R8");
        idle("R8");
        idle("R8");
        #1 oe_n = 1'b1;
        #1;
        chk(rvalid == 1'b0, "R8", {31'd0, rvalid}, '0);
        chk(rdata == '0, "R8", rdata, '0);
        oe_n = 1'b0;
        #1;
        chk(rvalid == 1'b1, "R8", {31'd0, rvalid}, 32'd1);
        chk(rdata == refm[8'h05], "R8", rdata, refm[8'h05]);

        // R9: random mix of loads, bursts, deselects, stalls and output enable
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = $urandom;
            if (k == 2000) burst_lin = 1'b0;
            cyc(r[2:0] == 3'd0, r[3] | r[4], r[5] & r[6], r[7],
                {6'b010000, r[9:8]}, r[13:10], $urandom, r[17:15] == 3'd0, "R9");
        end
        idle("R9");
        idle("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule